// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block records a bundle of probe signals into an on-chip sample memory, one sample per clock, so that a host can later read a window of activity around an event. An external trigger input marks the event. A signed holdoff sets where the recording window sits relative to that event. A positive value delays the window. Zero starts it on the trigger sample. A negative value keeps history from before the trigger, with the memory run as a ring.

Three capture modes are available. Single-shot records one contiguous window placed by the holdoff. Incremental stores only those cycles on which the trigger input is high. Immediate records a window at once and ignores the trigger. Every capture starts with an arm pulse, and an arm pulse in any state restarts the sequence. When the window is full, the block raises a done flag and reports three values: where the trigger sample landed, the address of the oldest sample, and how many pre-trigger samples are valid. The host uses these to unroll the ring in time order through a synchronous read port.

Top module: `la_capture`

## Requirements
- R1: During and after reset, `done` is 0 and `trig_index`, `oldest_addr` and `pre_count` are 0.
- R2: Immediate mode (`mode`=2'b10) writes DEPTH consecutive samples to addresses 0 to DEPTH-1. The first sample is taken on the clock after the arm clock. Trigger and holdoff have no effect. `done` rises on the clock after the last write.
- R3: Incremental mode (`mode`=2'b01) writes only the samples taken on clocks where `trig` is 1, at ascending addresses from 0, until DEPTH samples are stored. Holdoff has no effect.
- R4: Single-shot mode (`mode`=2'b00) with holdoff 0 stores the trigger-clock sample at address 0, followed by the next DEPTH-1 samples in order.
- R5: Single-shot mode with holdoff N>0 stores the sample taken N clocks after the trigger clock at address 0, followed by the next DEPTH-1 samples in order.
- R6: Single-shot mode with holdoff -N writes a sample into the ring on every armed clock. On a trigger it keeps P = min(number of armed clocks before the trigger, N, DEPTH-1) pre-trigger samples, the trigger sample and DEPTH-1-P later samples, DEPTH samples in all.
- R7: At completion, `trig_index` holds the address of the trigger sample, `oldest_addr` = (`trig_index` - P) mod DEPTH, and `pre_count` = P, all for a negative holdoff. For a holdoff of 0, or in incremental or immediate mode, all three are 0. They and `done` stay unchanged until the next arm.
- R8: A trigger that comes before N pre-trigger samples have been written is accepted, and `pre_count` gives the number actually held.
- R9: An arm pulse in any state clears `done` on the next clock and restarts the capture with the mode and holdoff present on the arm clock.
- R10: In single-shot mode with no trigger, `done` stays 0.
- R11: `rd_data` shows the word at `rd_addr` one clock after the address is presented.
- R12: `mode`=2'b11 behaves as single-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-clock pulse that starts a capture |
| trig | input | 1 | Trigger condition, evaluated outside this block |
| mode | input | 2 | Capture mode, sampled on the arm clock |
| holdoff | input | HOLD_W | Signed holdoff in clocks, sampled on the arm clock |
| probes | input | PROBE_W | Probe bundle sampled every clock |
| rd_addr | input | AW | Read address into the sample memory |
| rd_data | output | PROBE_W | Registered read data |
| done | output | 1 | Capture complete |
| trig_index | output | AW | Address of the trigger sample |
| oldest_addr | output | AW | Address of the oldest stored sample |
| pre_count | output | AW | Number of valid pre-trigger samples |

## Verification
A write pointer that skips or repeats shows up as read data that breaks the one-per-clock sequence of a counting probe bundle. It becomes visible as soon as the buffer is read back after `done`. A holdoff counter that is off by one shifts every stored value by one, so the first word read from address 0 already differs. A wrong pre-trigger count or ring origin gives `pre_count` or `oldest_addr` values that differ from the number of armed clocks, and these are visible on the ports on the clock after the capture finishes. A state machine that never reaches its final state leaves `done` low past the exact clock at which it must rise.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_t;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_INCR   = 2'b01,
    MODE_IMMED  = 2'b10,
    MODE_SPARE  = 2'b11
  } cap_mode_t;

endpackage

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/la_hold_decode.sv
module la_hold_decode #(
  parameter int DEPTH  = 64,
  parameter int HOLD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic signed [HOLD_W-1:0] holdoff,
  output logic [AW-1:0]            pre_lim,
  output logic [HOLD_W-1:0]        pos_delay,
  output logic                     is_pos
);

  localparam logic [31:0] LIM_MAX = 32'(DEPTH - 1);

  logic signed [31:0] h_ext;
  logic [31:0]        mag;

  always_comb begin
    h_ext     = {{(32-HOLD_W){holdoff[HOLD_W-1]}}, holdoff};
    mag       = 32'(-h_ext);
    pre_lim   = '0;
    pos_delay = '0;
    is_pos    = 1'b0;
    if (h_ext < 0) begin
      if (mag > LIM_MAX) begin
        pre_lim = AW'(LIM_MAX);
      end else begin
        pre_lim = mag[AW-1:0];
      end
    end else if (h_ext > 0) begin
      is_pos    = 1'b1;
      pos_delay = holdoff;
    end
  end

endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HOLD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic [AW-1:0]     pre_lim,
  input  logic [HOLD_W-1:0] pos_delay,
  input  logic              is_pos,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic              done,
  output logic [AW-1:0]     trig_idx,
  output logic [AW-1:0]     oldest,
  output logic [AW-1:0]     pre_cnt
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  cap_state_t        state;
  cap_mode_t         mode_q;
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     pre;
  logic [AW-1:0]     lim_q;
  logic [AW:0]       left;
  logic [HOLD_W-1:0] dly_q;
  logic [HOLD_W-1:0] hcnt;
  logic              pos_q;
  logic [AW:0]       post_left;

  assign post_left = FULL - (AW+1)'(1) - {1'b0, pre};

  always_comb begin
    unique case (state)
      ST_ARMED: we = !pos_q && (trig || (lim_q != '0));
      ST_CAPT:  we = (mode_q == MODE_INCR) ? trig : 1'b1;
      default:  we = 1'b0;
    endcase
  end

  assign waddr = wptr;
  assign done  = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= MODE_SINGLE;
      wptr     <= '0;
      pre      <= '0;
      lim_q    <= '0;
      left     <= '0;
      dly_q    <= '0;
      hcnt     <= '0;
      pos_q    <= 1'b0;
      trig_idx <= '0;
      oldest   <= '0;
      pre_cnt  <= '0;
    end else if (arm) begin
      mode_q   <= cap_mode_t'(mode);
      lim_q    <= pre_lim;
      dly_q    <= pos_delay;
      pos_q    <= is_pos;
      wptr     <= '0;
      pre      <= '0;
      hcnt     <= '0;
      left     <= FULL;
      trig_idx <= '0;
      oldest   <= '0;
      pre_cnt  <= '0;
      if (mode == MODE_IMMED || mode == MODE_INCR) begin
        state <= ST_CAPT;
      end else begin
        state <= ST_ARMED;
      end
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (pos_q) begin
            if (trig) begin
              if (dly_q == HOLD_W'(1)) begin
                state <= ST_CAPT;
              end else begin
                hcnt  <= dly_q - HOLD_W'(2);
                state <= ST_WAIT;
              end
            end
          end else if (trig) begin
            trig_idx <= wptr;
            oldest   <= wptr - pre;
            pre_cnt  <= pre;
            wptr     <= wptr + AW'(1);
            left     <= post_left;
            state    <= (post_left == '0) ? ST_DONE : ST_CAPT;
          end else if (lim_q != '0) begin
            wptr <= wptr + AW'(1);
            if (pre < lim_q) begin
              pre <= pre + AW'(1);
            end
          end
        end
        ST_WAIT: begin
          if (hcnt == '0) begin
            state <= ST_CAPT;
          end else begin
            hcnt <= hcnt - HOLD_W'(1);
          end
        end
        ST_CAPT: begin
          if (we) begin
            wptr <= wptr + AW'(1);
            left <= left - (AW+1)'(1);
            if (left == (AW+1)'(1)) begin
              state <= ST_DONE;
            end
          end
        end
        default: begin
          state <= state;
        end
      endcase
    end
  end

endmodule

// File: rtl/la_capture.sv
module la_capture #(
  parameter int PROBE_W = 8,
  parameter int DEPTH   = 64,
  parameter int HOLD_W  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     arm,
  input  logic                     trig,
  input  logic [1:0]               mode,
  input  logic signed [HOLD_W-1:0] holdoff,
  input  logic [PROBE_W-1:0]       probes,
  input  logic [AW-1:0]            rd_addr,
  output logic [PROBE_W-1:0]       rd_data,
  output logic                     done,
  output logic [AW-1:0]            trig_index,
  output logic [AW-1:0]            oldest_addr,
  output logic [AW-1:0]            pre_count
);

  logic [AW-1:0]     pre_lim;
  logic [HOLD_W-1:0] pos_delay;
  logic              is_pos;
  logic              we;
  logic [AW-1:0]     waddr;

  la_hold_decode #(
    .DEPTH  (DEPTH),
    .HOLD_W (HOLD_W)
  ) u_dec (
    .holdoff   (holdoff),
    .pre_lim   (pre_lim),
    .pos_delay (pos_delay),
    .is_pos    (is_pos)
  );

  la_capture_fsm #(
    .DEPTH  (DEPTH),
    .HOLD_W (HOLD_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .trig      (trig),
    .mode      (mode),
    .pre_lim   (pre_lim),
    .pos_delay (pos_delay),
    .is_pos    (is_pos),
    .we        (we),
    .waddr     (waddr),
    .done      (done),
    .trig_idx  (trig_index),
    .oldest    (oldest_addr),
    .pre_cnt   (pre_count)
  );

  la_sample_ram #(
    .DEPTH  (DEPTH),
    .DATA_W (PROBE_W)
  ) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (probes),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          done,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] trig_index
);

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !done);

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (rst)
    arm |=> !done);

  assert_no_write_when_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !we);

  assert_contiguous_writes_R4: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we) && !$past(arm) && !$past(rst)) |-> (waddr == $past(waddr) + AW'(1)));

  assert_done_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !$past(rst)) |-> $past(we));

  assert_report_held_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> (done && $stable(trig_index)));

endmodule

bind la_capture la_capture_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .arm        (arm),
  .done       (done),
  .we         (we),
  .waddr      (waddr),
  .trig_index (trig_index)
);

// File: tb/la_capture_test.sv
module la_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int DP = 16;
  localparam int HW = 8;
  localparam int AWB = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 arm = 1'b0;
  logic                 trig = 1'b0;
  logic [1:0]           mode = 2'b00;
  logic signed [HW-1:0] hold = '0;
  logic [PW-1:0]        pv = '0;
  logic [AWB-1:0]       rd_addr = '0;
  logic [PW-1:0]        rd_data;
  logic                 done;
  logic [AWB-1:0]       trig_index;
  logic [AWB-1:0]       oldest_addr;
  logic [AWB-1:0]       pre_count;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) pv <= pv + 8'd1;

  la_capture #(.PROBE_W(PW), .DEPTH(DP), .HOLD_W(HW)) uut (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .mode(mode),
    .holdoff(hold), .probes(pv), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .trig_index(trig_index), .oldest_addr(oldest_addr),
    .pre_count(pre_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_arm(input logic [1:0] m, input int h, output logic [PW-1:0] av);
    step();
    arm  = 1'b1;
    mode = m;
    hold = HW'(h);
    av   = pv;
    step();
    arm  = 1'b0;
  endtask

  // trigger on the k-th negedge counted from the arm negedge (k >= 1)
  task automatic fire(input int k, output logic [PW-1:0] tv);
    repeat (k-1) step();
    trig = 1'b1;
    tv   = pv;
    step();
    trig = 1'b0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      step();
    end
    chk(req, done, 1);
  endtask

  // read word at a and compare; data valid one clock after address
  task automatic rd_chk(input string req, input int a, input logic [PW-1:0] exp);
    rd_addr = AWB'(a);
    step();
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 trig_index", trig_index, 0);
    chk("R1 oldest_addr", oldest_addr, 0);
    chk("R1 pre_count", pre_count, 0);
  endtask

  task automatic t_immediate();
    logic [PW-1:0] av;
    do_arm(2'b10, -5, av);
    trig = 1'b1;              // ignored in this mode
    repeat (15) step();
    chk("R2 done before last write", done, 0);
    step();
    chk("R2 done after last write", done, 1);
    trig = 1'b0;
    chk("R7 immediate trig_index", trig_index, 0);
    chk("R7 immediate pre_count", pre_count, 0);
    for (int j = 0; j < DP; j++) rd_chk("R2 immediate data", j, av + PW'(j + 1));
  endtask

  task automatic t_incremental();
    logic [PW-1:0] av;
    logic [PW-1:0] exp_v [DP];
    int cnt = 0;
    int c = 0;
    do_arm(2'b01, 3, av);
    while (cnt < DP) begin
      trig = (c % 3 == 0);
      if (trig) begin
        exp_v[cnt] = pv;
        cnt++;
      end
      c++;
      step();
    end
    trig = 1'b0;
    wait_done("R3 incremental done");
    chk("R7 incremental oldest", oldest_addr, 0);
    for (int j = 0; j < DP; j++) rd_chk("R3 incremental data", j, exp_v[j]);
  endtask

  task automatic t_single_zero();
    logic [PW-1:0] av;
    logic [PW-1:0] tv;
    do_arm(2'b00, 0, av);
    repeat (30) step();
    chk("R10 no trigger keeps done low", done, 0);
    fire(1, tv);
    wait_done("R4 done");
    chk("R7 zero holdoff trig_index", trig_index, 0);
    for (int j = 0; j < DP; j++) rd_chk("R4 zero holdoff data", j, tv + PW'(j));
  endtask

  task automatic t_single_pos(input int n);
    logic [PW-1:0] av;
    logic [PW-1:0] tv;
    do_arm(2'b00, n, av);
    fire(5, tv);
    wait_done("R5 done");
    for (int j = 0; j < DP; j++) rd_chk("R5 positive holdoff data", j, tv + PW'(n + j));
  endtask

  task automatic t_single_neg(input logic [1:0] m, input int n, input int k, input string req);
    logic [PW-1:0] av;
    logic [PW-1:0] tv;
    int p;
    int ti;
    int od;
    do_arm(m, -n, av);
    fire(k, tv);
    wait_done(req);
    p  = k - 1;
    if (p > n) p = n;
    if (p > DP - 1) p = DP - 1;
    ti = (k - 1) % DP;
    od = (ti - p + DP) % DP;
    chk({req, " pre_count"}, pre_count, p);
    chk({req, " trig_index"}, trig_index, ti);
    chk({req, " oldest_addr"}, oldest_addr, od);
    for (int j = 0; j < DP; j++)
      rd_chk({req, " ring data"}, (od + j) % DP, tv - PW'(p) + PW'(j));
  endtask

  task automatic t_rearm();
    logic [PW-1:0] av;
    chk("R9 done before rearm", done, 1);
    step();
    arm  = 1'b1;
    mode = 2'b00;
    hold = '0;
    step();
    arm = 1'b0;
    chk("R9 done cleared after rearm", done, 0);
    // R12: spare mode acts as single-shot and waits for a trigger
    do_arm(2'b11, 0, av);
    repeat (25) step();
    chk("R12 spare mode waits for trigger", done, 0);
  endtask

  task automatic t_spare_fire();
    logic [PW-1:0] tv;
    fire(1, tv);
    wait_done("R12 spare mode done");
    rd_chk("R12 spare mode first word", 0, tv);
    rd_chk("R11 read latency", 1, tv + PW'(1));
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_immediate();
    t_incremental();
    t_single_zero();
    t_single_pos(1);
    t_single_pos(3);
    t_single_neg(2'b00, 8, 12, "R6 half depth");
    t_single_neg(2'b00, 16, 20, "R6 full depth");
    t_single_neg(2'b00, 8, 4, "R8 early trigger");
    t_rearm();
    t_spare_fire();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule